// File: doc/BRIEF.md
# Burst-Aware Slave Port Arbiter

This block decides which of several bus masters drives one slave port of a multi-master crossbar. Each master has a unique, statically configured priority level. On every beat the block either keeps the current owner or hands the port to the highest-priority requester. The handover can happen only at an arbitration point, and the rules that create those points depend on the kind of transfer the owner is running.

A fixed-length burst runs to its final beat without interruption. For single beats and undefined-length bursts, each master has a configured lockout count. The owner must complete that many accepted beats before another master can take the port. The count runs across all of the owner's back-to-back accesses, not only the current burst. It restarts from zero whenever the master wins the port again.

The slave side reports acceptance of the owner's current beat on one handshake line. A change of ownership is registered on that acceptance, so the new owner can present its first beat in the next cycle. When no other master is asking for the port, the current owner keeps it (parks).

Top module: `slave_port_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it, `grant` is all zeros and `owner_idx` is 0. No master owns the port.
- R2: When no master owns the port, the highest-priority requester is granted on the next clock edge. Its one-hot `grant` bit and its `owner_idx` are visible in the following cycle.
- R3: During an undefined-length burst (`m_kind` code 1) with lockout count N in 1..7, no other master receives the port until the owner's Nth accepted beat. The competitor is granted in the cycle after that beat.
- R4: The lockout count includes the owner's earlier single beats (`m_kind` code 0). With N=4, two singles followed by an undefined-length burst hand the port over after the burst's second beat.
- R5: Once the count has been met, each later accepted beat of the owner is an arbitration point, for as long as the owner keeps the port.
- R6: A master that regains the port starts counting from zero. N further accepted beats must pass before it can lose the port again.
- R7: A fixed-length burst (`m_kind` code 2) keeps the port until the beat that has `m_last` high. This holds for any lockout count, including 0.
- R8: A lockout count of 0 makes every accepted beat of an undefined-length burst an arbitration point, including the first beat.
- R9: When the owner stops requesting and no other master requests, the owner keeps `grant`. An idle owner that is not inside a fixed-length burst gives the port to any new requester on the next edge.
- R10: While the owner requests and `port_ack` is low, `grant` does not change.
- R11: `grant` has at most one bit set, and that bit matches `owner_idx`. At an arbitration point, the requester with the larger `cfg_prio` level wins, and a lower-level requester never displaces a higher-level owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | NUM_MASTERS | Per-master request for the port |
| m_kind | input | 2*NUM_MASTERS | Per-master transfer kind: 0 single, 1 undefined-length burst, 2 fixed-length burst (3 is treated as single) |
| m_last | input | NUM_MASTERS | Per-master flag marking the final beat of a fixed-length burst |
| port_ack | input | 1 | The slave accepts the owner's current beat |
| cfg_prio | input | PRIO_W*NUM_MASTERS | Priority level per master; the larger value wins; levels are unique |
| cfg_lockout | input | LOCK_W*NUM_MASTERS | Per-master lockout beat count (0 to 7) |
| grant | output | NUM_MASTERS | One-hot grant of the port |
| owner_idx | output | $clog2(NUM_MASTERS) | Index of the current owner; 0 when no master owns the port |

## Verification
The owner register is updated on the edge that samples an accepted beat, or on the edge that samples an idle owner. The new `grant` and `owner_idx` therefore appear one cycle after the stimulus that creates the arbitration point. The bench changes inputs one time unit after a rising edge and reads outputs at the same point, after each edge. Each check thus sees the result of exactly the beats accepted so far. In the lockout scenarios, the bench counts accepted beats one edge at a time and checks the owner after every edge. A handover that comes one beat early or one beat late fails a check.

// File: rtl/spa_pkg.sv
// Package: shared transfer-kind encoding for the slave port arbiter.
// Assumes each master drives a two-bit kind code alongside its request.
package spa_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        XFER_SINGLE = 2'd0,
        XFER_UNDEF  = 2'd1,
        XFER_FIXED  = 2'd2,
        XFER_RSVD   = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/spa_prio_pick.sv
// Module: spa_prio_pick
// Purpose: finds the requester with the largest priority level.
// Assumes: priority levels are unique; if two are equal, the lower index
// is reported. Purely combinational.
module spa_prio_pick #(
    parameter int NUM_MASTERS = 4,
    parameter int PRIO_W      = 2,
    localparam int IDX_W      = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic [NUM_MASTERS*PRIO_W-1:0] prio_flat,
    output logic [IDX_W-1:0]              win_idx,
    output logic                          any_req
);

    logic [NUM_MASTERS-1:0] wins;

    for (genvar gi = 0; gi < NUM_MASTERS; gi++) begin : g_cand
        logic beats_all;
        // A requester wins when no other requester has a larger level.
        always_comb begin
            beats_all = req[gi];
            for (int j = 0; j < NUM_MASTERS; j++) begin
                if (j != gi && req[j] &&
                    (prio_flat[j*PRIO_W +: PRIO_W] > prio_flat[gi*PRIO_W +: PRIO_W])) begin
                    beats_all = 1'b0;
                end
            end
        end
        assign wins[gi] = beats_all;
    end

    // Encode the winner; the lowest index is kept on a tie.
    always_comb begin
        win_idx = '0;
        for (int k = NUM_MASTERS - 1; k >= 0; k--) begin
            if (wins[k]) begin
                win_idx = IDX_W'(k);
            end
        end
    end

    assign any_req = |req;

endmodule

// File: rtl/spa_beat_counter.sv
// Module: spa_beat_counter
// Purpose: counts one master's accepted beats during its current tenure
// on the port and reports whether the beat being taken reaches the
// lockout count.
// Assumes: the counter clears in every cycle in which the master does
// not own the port, so a regained tenure starts from zero. Saturates.
module spa_beat_counter #(
    parameter int LOCK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_owner,
    input  logic              beat_taken,
    input  logic [LOCK_W-1:0] lockout,
    output logic              lock_met
);

    logic [LOCK_W-1:0] cnt_q;

    // Count accepted beats while owning; clear when not owning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!is_owner) begin
            cnt_q <= '0;
        end else if (beat_taken && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The beat being taken is the (cnt_q+1)th one of this tenure.
    assign lock_met = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lockout};

endmodule

// File: rtl/spa_hold_ctrl.sv
// Module: spa_hold_ctrl
// Purpose: decides in each cycle whether the port is open for
// arbitration, given the owner's beat, its kind and its lockout state.
// Assumes: a fixed-length burst keeps the same kind until its last beat.
module spa_hold_ctrl
    import spa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       owner_valid,
    input  logic       owner_req,
    input  logic       beat_taken,
    input  xfer_kind_e cur_kind,
    input  logic       cur_last,
    input  logic       owner_met,
    output logic       arb_open
);

    logic fixed_lock_q;

    // Remember that a fixed-length burst is in progress between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fixed_lock_q <= 1'b0;
        end else if (!owner_valid) begin
            fixed_lock_q <= 1'b0;
        end else if (beat_taken) begin
            fixed_lock_q <= (cur_kind == XFER_FIXED) && !cur_last;
        end
    end

    // Open the port for arbitration at a permitted beat boundary or when the owner is idle.
    always_comb begin
        if (!owner_valid) begin
            arb_open = 1'b1;
        end else if (beat_taken) begin
            if (cur_kind == XFER_FIXED) begin
                arb_open = cur_last;
            end else begin
                arb_open = owner_met;
            end
        end else begin
            arb_open = !owner_req && !fixed_lock_q;
        end
    end

endmodule

// File: rtl/slave_port_arbiter.sv
// Module: slave_port_arbiter
// Purpose: one slave port's owner arbiter. Fixed-priority winner
// selection, with per-master beat lockout for single beats and
// undefined-length bursts, and no interruption of fixed-length bursts.
// Assumes: port_ack refers to the current owner's beat; configuration
// inputs are static while reset is released.
module slave_port_arbiter
    import spa_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int PRIO_W      = 2,
    parameter int LOCK_W      = 3,
    localparam int IDX_W      = $clog2(NUM_MASTERS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        m_req,
    input  logic [NUM_MASTERS*KIND_W-1:0] m_kind,
    input  logic [NUM_MASTERS-1:0]        m_last,
    input  logic                          port_ack,
    input  logic [NUM_MASTERS*PRIO_W-1:0] cfg_prio,
    input  logic [NUM_MASTERS*LOCK_W-1:0] cfg_lockout,
    output logic [NUM_MASTERS-1:0]        grant,
    output logic [IDX_W-1:0]              owner_idx
);

    logic [IDX_W-1:0]       owner_q;
    logic                   owner_vld_q;
    logic [IDX_W-1:0]       win_idx;
    logic                   any_req;
    logic                   owner_req;
    logic                   beat_taken;
    logic                   arb_open;
    logic                   owner_met;
    logic [NUM_MASTERS-1:0] met_vec;
    logic [NUM_MASTERS-1:0] own_vec;
    xfer_kind_e             cur_kind;
    logic                   cur_last;

    // Owner's view of the shared per-master inputs.
    assign owner_req  = owner_vld_q && m_req[owner_q];
    assign beat_taken = owner_req && port_ack;
    assign cur_kind   = xfer_kind_e'(m_kind[owner_q*KIND_W +: KIND_W]);
    assign cur_last   = m_last[owner_q];
    assign owner_met  = met_vec[owner_q];

    spa_prio_pick #(
        .NUM_MASTERS (NUM_MASTERS),
        .PRIO_W      (PRIO_W)
    ) u_pick (
        .req       (m_req),
        .prio_flat (cfg_prio),
        .win_idx   (win_idx),
        .any_req   (any_req)
    );

    for (genvar gm = 0; gm < NUM_MASTERS; gm++) begin : g_master
        assign own_vec[gm] = owner_vld_q && (owner_q == IDX_W'(gm));

        spa_beat_counter #(
            .LOCK_W (LOCK_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .is_owner   (own_vec[gm]),
            .beat_taken (beat_taken && own_vec[gm]),
            .lockout    (cfg_lockout[gm*LOCK_W +: LOCK_W]),
            .lock_met   (met_vec[gm])
        );
    end

    spa_hold_ctrl u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .owner_valid (owner_vld_q),
        .owner_req   (owner_req),
        .beat_taken  (beat_taken),
        .cur_kind    (cur_kind),
        .cur_last    (cur_last),
        .owner_met   (owner_met),
        .arb_open    (arb_open)
    );

    // Register the new owner at an open arbitration point with a requester present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q     <= '0;
            owner_vld_q <= 1'b0;
        end else if (arb_open && any_req) begin
            owner_q     <= win_idx;
            owner_vld_q <= 1'b1;
        end
    end

    assign grant     = own_vec;
    assign owner_idx = owner_q;

endmodule

// File: rtl/spa_checker.sv
// Module: spa_checker
// Purpose: temporal checks on the arbiter's ports, bound to every
// instance of slave_port_arbiter.
// Assumes: the kind encoding from spa_pkg.
module spa_checker
    import spa_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W      = $clog2(NUM_MASTERS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_MASTERS-1:0]        m_req,
    input logic [NUM_MASTERS*KIND_W-1:0] m_kind,
    input logic [NUM_MASTERS-1:0]        m_last,
    input logic                          port_ack,
    input logic [NUM_MASTERS-1:0]        grant,
    input logic [IDX_W-1:0]              owner_idx
);

    logic       own_busy;
    xfer_kind_e own_kind;
    logic       own_last;

    assign own_busy = |(grant & m_req);
    assign own_kind = xfer_kind_e'(m_kind[owner_idx*KIND_W +: KIND_W]);
    assign own_last = m_last[owner_idx];

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (grant == '0));

    // R2
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == '0) && (|m_req)) |=> (grant != '0));

    // R9
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> (grant != '0));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && !port_ack) |=> $stable(grant));

    // R7
    fixed_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_busy && port_ack && (own_kind == XFER_FIXED) && !own_last) |=> $stable(grant));

    // R11
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> grant[owner_idx]);

endmodule

bind slave_port_arbiter spa_checker #(
    .NUM_MASTERS (NUM_MASTERS)
) u_spa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_req     (m_req),
    .m_kind    (m_kind),
    .m_last    (m_last),
    .port_ack  (port_ack),
    .grant     (grant),
    .owner_idx (owner_idx)
);

// File: tb/sim_slave_port_arbiter.sv
module sim_slave_port_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NM = 4;

    logic        clk;
    logic        rst_n;
    logic [3:0]  req;
    logic [7:0]  kind;
    logic [3:0]  last;
    logic        ack;
    logic [7:0]  prio;
    logic [11:0] lock;
    logic [3:0]  grant;
    logic [1:0]  owner_idx;

    int n_chk  = 0;
    int n_fail = 0;

    slave_port_arbiter #(.NUM_MASTERS(NM), .PRIO_W(2), .LOCK_W(3)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_req       (req),
        .m_kind      (kind),
        .m_last      (last),
        .port_ack    (ack),
        .cfg_prio    (prio),
        .cfg_lockout (lock),
        .grant       (grant),
        .owner_idx   (owner_idx)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_owner(input string rq, input int idx);
        chk(rq, int'(grant), 1 << idx);
        chk(rq, int'(owner_idx), idx);
    endtask

    task automatic set_m(input int i, input logic r, input logic [1:0] k, input logic l);
        req[i] = r;
        kind[i*2 +: 2] = k;
        last[i] = l;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; kind = '0; last = '0; ack = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic set_lock(input int i, input int n);
        lock[i*3 +: 3] = 3'(n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req = 4'hF; ack = 1'b1;
        tick();
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 idx in reset", int'(owner_idx), 0);
        do_reset();
        chk("R1 grant after reset", int'(grant), 0);
    endtask

    task automatic t_idle_grant();
        do_reset();
        set_m(1, 1, 2'd0, 0); set_m(2, 1, 2'd0, 0);
        chk("R2 no grant before edge", int'(grant), 0);
        tick();
        chk_owner("R2 highest requester", 2);
    endtask

    task automatic t_lockout();
        do_reset();
        set_lock(1, 3);
        set_m(1, 1, 2'd1, 0);
        tick();
        chk_owner("R3 granted", 1);
        set_m(3, 1, 2'd0, 0); ack = 1'b1;
        tick(); chk_owner("R3 beat1 held", 1);
        tick(); chk_owner("R3 beat2 held", 1);
        tick(); chk_owner("R3 beat3 handover", 3);
    endtask

    task automatic t_span();
        do_reset();
        set_lock(1, 4);
        set_m(1, 1, 2'd0, 0);
        tick();
        chk_owner("R4 granted", 1);
        set_m(2, 1, 2'd0, 0); ack = 1'b1;
        tick(); chk_owner("R4 single1 held", 1);
        tick(); chk_owner("R4 single2 held", 1);
        set_m(1, 1, 2'd1, 0);
        tick(); chk_owner("R4 burst beat1 held", 1);
        tick(); chk_owner("R4 burst beat2 handover", 2);
    endtask

    task automatic t_open_restart();
        do_reset();
        set_lock(1, 2); set_lock(3, 0);
        set_m(1, 1, 2'd1, 0);
        tick();
        ack = 1'b1;
        tick(); tick(); tick();
        chk_owner("R5 parked past count", 1);
        set_m(3, 1, 2'd0, 0);
        tick(); chk_owner("R5 later beat is arb point", 3);
        tick(); chk_owner("R11 higher owner keeps", 3);
        set_m(3, 0, 2'd0, 0); ack = 1'b0;
        tick(); chk_owner("R9 idle owner hands over", 1);
        set_m(3, 1, 2'd0, 0); ack = 1'b1;
        tick(); chk_owner("R6 restart beat1 held", 1);
        tick(); chk_owner("R6 restart beat2 handover", 3);
    endtask

    task automatic t_fixed();
        do_reset();
        set_lock(1, 0);
        set_m(1, 1, 2'd2, 0);
        tick();
        set_m(3, 1, 2'd0, 0); ack = 1'b1;
        tick(); chk_owner("R7 fixed beat1 held", 1);
        tick(); chk_owner("R7 fixed beat2 held", 1);
        tick(); chk_owner("R7 fixed beat3 held", 1);
        last[1] = 1'b1;
        tick(); chk_owner("R7 fixed last handover", 3);
    endtask

    task automatic t_zero_stall();
        do_reset();
        set_lock(1, 0);
        set_m(1, 1, 2'd1, 0);
        tick();
        set_m(3, 1, 2'd0, 0); ack = 1'b0;
        tick(); chk_owner("R10 stall held 1", 1);
        tick(); chk_owner("R10 stall held 2", 1);
        ack = 1'b1;
        tick(); chk_owner("R8 first beat handover", 3);
    endtask

    task automatic t_park();
        do_reset();
        set_m(2, 1, 2'd0, 0);
        tick();
        set_m(2, 0, 2'd0, 0); ack = 1'b1;
        tick(); tick(); tick();
        chk_owner("R9 parked", 2);
        set_m(0, 1, 2'd0, 0);
        tick(); chk_owner("R9 idle owner yields", 0);
    endtask

    task automatic t_prio();
        prio = 8'b00_01_10_11;
        do_reset();
        req = 4'hF;
        tick(); chk_owner("R11 swapped levels", 0);
        prio = 8'b11_10_01_00;
    endtask

    initial begin
        rst_n = 1'b0;
        req = '0; kind = '0; last = '0; ack = 1'b0;
        prio = 8'b11_10_01_00;
        lock = '0;
        t_reset();
        t_idle_grant();
        t_lockout();
        t_span();
        t_open_restart();
        t_fixed();
        t_zero_stall();
        t_park();
        t_prio();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule